// File: doc/BRIEF.md
# Audio Sample FIFO with Threshold Service Request

This block holds the sample words exchanged between software and the serializer of one audio sub-block. A single eight-entry first-in first-out store sits between the two. A direction input decides who fills it and who drains it. In transmit mode, software writes samples over a simple register strobe interface and the serializer removes them. In receive mode, the serializer deposits samples and software reads them back. The word at the head of the store is always visible on a read-data output, and no extra cycle is needed to fetch it.

The block summarises its occupancy as a coarse three-bit level code. It compares that code with a three-bit threshold setting and derives one service request flag. The same flag serves both directions. When transmitting, it means "refill me". When receiving, it means "drain me". A mask input gates the flag onto an interrupt output.

Neither side has back-pressure. The level code tells software how much room or data is left. A write to a full store is dropped. A removal from an empty store leaves the store unchanged. Either event sets a sticky error flag, and software clears that flag with a one-cycle clear strobe.

Top module: `aud_fifo_req`

## Requirements
- R1: The level code is a function of occupancy n (depth 8): 000 for n=0, 001 for n=1, 010 for n=2..3, 011 for n=4..5, 100 for n=6..7, 101 for n=8. It moves by at most one step per cycle.
- R2: With `dir_rx`=0, `bus_wr` adds `bus_wdata` and `ser_pop` removes the head. With `dir_rx`=1, `ser_push` adds `ser_data` and `bus_rd` removes the head. The other two strobes have no effect.
- R3: Words leave in the order they entered. While the store is not empty, `head_data` shows the oldest word.
- R4: In transmit mode, `req` is 1 exactly when the level code is less than or equal to the effective threshold. Threshold 000 therefore requests only while empty, and 100 requests while not full.
- R5: In receive mode, `req` is 1 exactly when the level code is greater than the effective threshold. Threshold 000 therefore requests while not empty, and 100 requests only when full.
- R6: Threshold values 101, 110 and 111 behave as 100.
- R7: `irq` equals `req` AND `req_en`, combinationally.
- R8: An add while the store holds 8 words is dropped and sets `err` in the next cycle, even if a removal happens in the same cycle.
- R9: A removal while the store is empty leaves it unchanged and sets `err` in the next cycle, even if an add happens in the same cycle.
- R10: `err` stays set until a cycle with `err_clr`=1 and no new error event. A new error event in the same cycle as the clear keeps `err` set.
- R11: After reset, the store is empty, the level code is 000 and `err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_rx | input | 1 | 0 transmit, 1 receive |
| thresh | input | 3 | Request threshold code |
| req_en | input | 1 | Interrupt mask, 1 passes the request |
| bus_wr | input | 1 | Software write strobe |
| bus_wdata | input | 16 | Software write data |
| bus_rd | input | 1 | Software read strobe (removes the head) |
| ser_push | input | 1 | Serializer deposit strobe |
| ser_data | input | 16 | Serializer deposit data |
| ser_pop | input | 1 | Serializer removal strobe |
| err_clr | input | 1 | Clear strobe for the error flag |
| head_data | output | 16 | Oldest stored word |
| level_code | output | 3 | Coarse fill level |
| req | output | 1 | Service request flag |
| irq | output | 1 | Masked request |
| err | output | 1 | Sticky overflow/underflow flag |

## Verification
Every cycle, the assertions check the interrupt gating, the single-step movement of the level code, and the request at the empty level in both directions. They also check that an overflow or underflow attempt raises the error flag and that a refused add leaves the full level unchanged. Ordering of data, the full threshold/level matrix, clamping of high threshold codes, ignored strobes of the inactive direction and the clear-versus-set race depend on history. Only the bench's reference model, run over directed and seeded random traffic, can show these.

// File: rtl/aud_fifo_pkg.sv
package aud_fifo_pkg;
  typedef logic [2:0] lvl_t;

  localparam lvl_t LVL_EMPTY = 3'd0;
  localparam lvl_t LVL_LOW   = 3'd1;
  localparam lvl_t LVL_QTR   = 3'd2;
  localparam lvl_t LVL_HALF  = 3'd3;
  localparam lvl_t LVL_3QTR  = 3'd4;
  localparam lvl_t LVL_FULL  = 3'd5;

  // coarse occupancy code; depth is a power of two and at least 4
  function automatic lvl_t level_of(input int n, input int depth);
    int q;
    q = depth / 4;
    if (n == 0)            return LVL_EMPTY;
    else if (n < q)        return LVL_LOW;
    else if (n < 2 * q)    return LVL_QTR;
    else if (n < 3 * q)    return LVL_HALF;
    else if (n < depth)    return LVL_3QTR;
    else                   return LVL_FULL;
  endfunction
endpackage

// File: rtl/aud_fifo_mem.sv
module aud_fifo_mem #(
  parameter int DEPTH = 8,
  parameter int W     = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          ovf,
  output logic          udf
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          full, empty, do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign ovf     = push && full;
  assign udf     = pop && empty;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/aud_fifo_thresh.sv
module aud_fifo_thresh
  import aud_fifo_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] count,
  input  logic          dir_rx,
  input  logic [2:0]    thresh,
  output lvl_t          level,
  output logic          req
);
  lvl_t thr_eff;

  always_comb begin
    level   = level_of(32'(count), DEPTH);
    thr_eff = (thresh > LVL_3QTR) ? LVL_3QTR : thresh;
    if (dir_rx) req = (level > thr_eff);
    else        req = (level <= thr_eff);
  end
endmodule

// File: rtl/aud_fifo_req.sv
module aud_fifo_req
  import aud_fifo_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int W     = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dir_rx,
  input  logic [2:0]   thresh,
  input  logic         req_en,
  input  logic         bus_wr,
  input  logic [W-1:0] bus_wdata,
  input  logic         bus_rd,
  input  logic         ser_push,
  input  logic [W-1:0] ser_data,
  input  logic         ser_pop,
  input  logic         err_clr,
  output logic [W-1:0] head_data,
  output logic [2:0]   level_code,
  output logic         req,
  output logic         irq,
  output logic         err
);
  logic          push, pop, ovf, udf;
  logic [W-1:0]  push_data;
  logic [CW-1:0] count;
  lvl_t          level;

  // direction routing: only the active side may add or remove
  assign push      = dir_rx ? ser_push : bus_wr;
  assign push_data = dir_rx ? ser_data : bus_wdata;
  assign pop       = dir_rx ? bus_rd   : ser_pop;

  aud_fifo_mem #(.DEPTH(DEPTH), .W(W)) u_mem (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
    .pop(pop), .head(head_data), .count(count), .ovf(ovf), .udf(udf)
  );

  aud_fifo_thresh #(.DEPTH(DEPTH)) u_thr (
    .count(count), .dir_rx(dir_rx), .thresh(thresh),
    .level(level), .req(req)
  );

  assign level_code = level;
  assign irq        = req && req_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            err <= 1'b0;
    else if (ovf || udf)   err <= 1'b1;
    else if (err_clr)      err <= 1'b0;
  end
endmodule

// File: rtl/aud_fifo_req_chk.sv
module aud_fifo_req_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dir_rx,
  input logic       req_en,
  input logic       bus_wr,
  input logic       ser_push,
  input logic       ser_pop,
  input logic       bus_rd,
  input logic [2:0] level_code,
  input logic       req,
  input logic       irq,
  input logic       err
);
  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (req && req_en)); // R7
  AST_LVL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ({1'b0, level_code} <= {1'b0, $past(level_code)} + 4'd1) &&
             ({1'b0, $past(level_code)} <= {1'b0, level_code} + 4'd1)); // R1
  AST_TX_EMPTY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_rx && level_code == 3'd0) |-> req); // R4
  AST_RX_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_rx && level_code == 3'd0) |-> !req); // R5
  AST_OVF_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (((!dir_rx && bus_wr) || (dir_rx && ser_push)) && level_code == 3'd5) |=> err); // R8
  AST_UDF_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (((!dir_rx && ser_pop) || (dir_rx && bus_rd)) && level_code == 3'd0) |=> err); // R9
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_rx && bus_wr && !ser_pop && level_code == 3'd5) |=> level_code == 3'd5); // R8
endmodule

bind aud_fifo_req aud_fifo_req_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dir_rx(dir_rx), .req_en(req_en),
  .bus_wr(bus_wr), .ser_push(ser_push), .ser_pop(ser_pop), .bus_rd(bus_rd),
  .level_code(level_code), .req(req), .irq(irq), .err(err)
);

// File: tb/sim_aud_fifo_req.sv
module sim_aud_fifo_req;
  localparam int DEPTH = 8;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dir_rx = 0, req_en = 0, bus_wr = 0, bus_rd = 0, ser_push = 0, ser_pop = 0, err_clr = 0;
  logic [2:0] thresh = 0;
  logic [W-1:0] bus_wdata = 0, ser_data = 0, head_data;
  logic [2:0] level_code;
  logic req, irq, err;

  int total = 0, bad = 0;
  logic [W-1:0] mq[$];
  logic m_err = 1'b0;

  always #2 clk = ~clk;

  aud_fifo_req u0 (.*);

  function automatic int exp_level(int n);
    if (n == 0) return 0;
    if (n < 2) return 1;
    if (n < 4) return 2;
    if (n < 6) return 3;
    if (n < 8) return 4;
    return 5;
  endfunction

  function automatic logic exp_req(int lvl, logic rx, int thr);
    int t;
    t = (thr > 4) ? 4 : thr;
    return rx ? (lvl > t) : (lvl <= t);
  endfunction

  task automatic chk(string r, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", r, act, exp, $time);
    end
  endtask

  // drive at negedge, check outputs before the edge, then advance the model
  task automatic step(logic rx, logic [2:0] th, logic en, logic wr, logic rd,
                      logic sp, logic sq, logic clr);
    logic add, rem, ev;
    @(negedge clk);
    dir_rx = rx; thresh = th; req_en = en; bus_wr = wr; bus_rd = rd;
    ser_push = sp; ser_pop = sq; err_clr = clr;
    bus_wdata = W'($urandom); ser_data = W'($urandom);
    #1;
    chk("R1 level", int'(level_code), exp_level(mq.size()));
    chk(rx ? "R5 req" : "R4/R6 req", int'(req), int'(exp_req(exp_level(mq.size()), rx, int'(th))));
    chk("R7 irq", int'(irq), int'(exp_req(exp_level(mq.size()), rx, int'(th)) && en));
    chk("R10 err", int'(err), int'(m_err));
    if (mq.size() != 0) chk("R3 head", int'(head_data), int'(mq[0]));
    add = rx ? sp : wr;
    rem = rx ? rd : sq;
    ev = (add && mq.size() == DEPTH) || (rem && mq.size() == 0);
    begin
      logic full0, empty0;
      full0 = (mq.size() == DEPTH);
      empty0 = (mq.size() == 0);
      if (rem && !empty0) void'(mq.pop_front());
      if (add && !full0) mq.push_back(rx ? ser_data : bus_wdata);
    end
    if (ev) m_err = 1'b1;
    else if (clr) m_err = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #5;
    chk("R11 level", int'(level_code), 0);
    chk("R11 err", int'(err), 0);
    rst_n = 1'b1;
    // R2 inactive strobes in transmit: ser_push/bus_rd have no effect
    step(0, 0, 1, 0, 1, 1, 0, 0);
    step(0, 0, 1, 0, 0, 1, 0, 0);
    // R8 fill transmit to full, then overflow
    for (int i = 0; i < 9; i++) step(0, 3'(i % 8), 1, 1, 0, 0, 0, 0);
    step(0, 4, 1, 1, 1, 0, 1, 0); // add to full with removal: add dropped (R8)
    step(0, 7, 1, 0, 0, 0, 0, 1); // clear
    // R9 drain to empty, then underflow with simultaneous add
    for (int i = 0; i < 8; i++) step(0, 1, 0, 0, 0, 0, 1, 0);
    step(0, 2, 1, 1, 0, 0, 1, 1); // R10 error set wins over clear
    step(0, 2, 1, 0, 0, 0, 0, 1);
    step(0, 2, 1, 0, 0, 0, 0, 0);
    // receive mode: R2 inactive bus_wr/ser_pop, R5 thresholds, R6 clamp
    for (int i = 0; i < 10; i++) step(1, 3'(i % 8), 1, 1, 0, 1, 1, 0);
    for (int i = 0; i < 10; i++) step(1, 3'((i + 3) % 8), 1, 0, 1, 0, 0, 0);
    // seeded random traffic
    for (int i = 0; i < 3000; i++) begin
      logic rx;
      rx = (i / 200) % 2 == 1;
      step(rx, 3'($urandom), 1'($urandom), ($urandom % 3) != 0, ($urandom % 3) == 0,
           ($urandom % 3) != 0, ($urandom % 3) == 0, ($urandom % 16) == 0);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule